// File: doc/BRIEF.md
# ULPI Transceiver UART-Mode Sequencer

This block sits on the transceiver side of a ULPI link and steers the transceiver between ordinary synchronous operation and transparent UART mode. When configuration requests UART mode, it turns on the weak pull-up controls, takes the bus by raising DIR, and lets one turnaround cycle pass. It then drives the data bus for a fixed number of cycles with DATA0 held high, so that a slow link sees a clean high level. Only after that does it enable the pass-through buffers between the data pins and the line pins. Unless a keep-clock bit was set before entry, the transceiver output clock stops while UART mode is active.

UART mode ends in one of two ways. Raising STP or toggling chip select gives an orderly exit: a single EXIT cycle turns the buffers off, restarts the clock, clears the mode request and then releases DIR. Holding chip select low for longer than a power-down threshold and then raising it issues a power-on reset pulse and forces the block back to synchronous mode from any state. The threshold is counted on the free-running reference clock that runs this block, so it still works while the output clock is stopped.

Independently of the mode, unmasked interrupt events are latched and drive INT until the link reads the latch.

Top module: `ulpi_uart_seq`

## Requirements
- R1: `clkOutEn` is low in UART_ACTIVE unless `cfgClkKeep` was 1 in the cycle the UART request was accepted. It is high in every other state.
- R2: `pullupEn` is high from the turnaround cycle through UART_ACTIVE. It is low in SYNC and EXIT.
- R3: `dir` rises in the cycle after `cfgUartReq` is sampled high in SYNC. For that first cycle the bus is not driven (turnaround). For the next PRE_CYCLES (default 5) cycles, `ulpiDataOe` is 1 and `ulpiDataOut` is 8'h01, with DATA0 as bit 0. At all other times `ulpiDataOut` is 0 and `ulpiDataOe` is 0.
- R4: `uartBufEn` is high only in UART_ACTIVE, which follows the drive window directly. It is never high while the bus is driven.
- R5: In UART_ACTIVE, `stp`=1 or any change of `chipSel` moves the block to EXIT for one cycle. In EXIT, `dir` is still 1, buffers and pull-ups are off, the clock is on and `uartModeClr` is 1. The cycle after that, `dir` is 0.
- R6: An event bit set in both `intEvt` and `intMask` (1 = enabled) sets the matching `intLatch` bit on the next clock. `intOut` is the OR of `intLatch`. Masked events are ignored.
- R7: `intLatchRd` clears all latched bits on the next clock, except bits that see a new unmasked event in that same cycle.
- R8: If `chipSel` rises after being sampled low for more than PD_CYCLES consecutive clocks, then on the next clock the state is SYNC, `porOut` is 1 for one cycle and the latch holds only the events of that cycle. A low time of exactly PD_CYCLES does not do this.
- R9: During turnaround and the drive window, `stp` and short `chipSel` toggles are ignored. Only the R8 reset aborts entry.
- R10: After a synchronous reset (`rstN`=0), the state is SYNC. All outputs are low except `clkOutEn`, and the latch is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgUartReq | input | 1 | UART-mode control bit from configuration |
| cfgClkKeep | input | 1 | Keep output clock running in UART mode |
| chipSel | input | 1 | Chip select, active high |
| stp | input | 1 | ULPI STP from the link |
| intEvt | input | INT_W | Interrupt event inputs |
| intMask | input | INT_W | Interrupt enables, 1 = enabled |
| intLatchRd | input | 1 | Interrupt latch read strobe |
| dir | output | 1 | ULPI DIR |
| ulpiDataOut | output | 8 | ULPI data driven by the transceiver |
| ulpiDataOe | output | 1 | ULPI data output enable |
| clkOutEn | output | 1 | Transceiver output clock enable |
| pullupEn | output | 1 | Weak pull-up enable on DP and DATA0 |
| uartBufEn | output | 1 | Data-pin to line-pin UART buffer enable |
| uartModeClr | output | 1 | Clear strobe for the UART-mode control bit |
| porOut | output | 1 | Power-on reset pulse |
| intOut | output | 1 | Interrupt line |
| intLatch | output | INT_W | Latched interrupt sources |

## Verification
On every cycle, the assertions check the following local rules:
- A drive window always begins after a cycle with DIR already high.
- The UART buffers never overlap bus drive.
- STP in UART mode always drops the buffers.
- An unmasked event always raises INT.
- A read with no new event always clears INT.
- A reset pulse always coincides with DIR released.

Other properties need whole scenarios and the cycle model in the bench:
- The exact length of the turnaround and the five-cycle precharge.
- The clock-keep choice captured at entry.
- Stimuli being ignored during entry.
- The boundary between a low time of exactly PD_CYCLES and one cycle longer.

// File: rtl/ulpi_uart_pkg.sv
package ulpi_uart_pkg;

  typedef enum logic [2:0] {
    SYNC,
    ENTRY_TURNAROUND,
    PRECHARGE,
    UART_ACTIVE,
    EXIT
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic loadKeep;
    logic pcStart;
    logic pcRun;
  } ctlStrobes_t;

  // datapath -> control status
  typedef struct packed {
    logic pcDone;
    logic csToggle;
    logic csLongRise;
    logic keepClk;
  } dpStatus_t;

endpackage

// File: rtl/uart_seq_datapath.sv
module uart_seq_datapath
  import ulpi_uart_pkg::*;
#(
  parameter int INT_W      = 4,
  parameter int PRE_CYCLES = 5,
  parameter int PD_CYCLES  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic             cfgClkKeep,
  input  logic             chipSel,
  input  logic [INT_W-1:0] intEvt,
  input  logic [INT_W-1:0] intMask,
  input  logic             intLatchRd,
  output dpStatus_t        status,
  output logic             intOut,
  output logic [INT_W-1:0] intLatch
);

  localparam int PW = $clog2(PRE_CYCLES + 1);
  localparam int CW = $clog2(PD_CYCLES + 2);
  localparam logic [PW-1:0] PC_LAST = PW'(PRE_CYCLES - 1);
  localparam logic [CW-1:0] LOW_SAT = CW'(PD_CYCLES + 1);

  logic [PW-1:0]    pcCnt;
  logic [CW-1:0]    lowCnt;
  logic             csQ;
  logic             keepQ;
  logic             longRise;
  logic [INT_W-1:0] newEvt;
  logic [INT_W-1:0] latchBase;

  // precharge window counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcCnt <= '0;
    end else if (strobes.pcStart) begin
      pcCnt <= '0;
    end else if (strobes.pcRun) begin
      pcCnt <= pcCnt + 1'b1;
    end
  end

  // clock-keep capture at entry
  always_ff @(posedge clk) begin
    if (!rstN) begin
      keepQ <= 1'b0;
    end else if (strobes.loadKeep) begin
      keepQ <= cfgClkKeep;
    end
  end

  // chip-select edge and low-time tracking on the reference clock
  always_ff @(posedge clk) begin
    if (!rstN) begin
      csQ    <= 1'b1;
      lowCnt <= '0;
    end else begin
      csQ <= chipSel;
      if (chipSel) begin
        lowCnt <= '0;
      end else if (lowCnt != LOW_SAT) begin
        lowCnt <= lowCnt + 1'b1;
      end
    end
  end

  assign longRise = chipSel && !csQ && (lowCnt == LOW_SAT);

  // interrupt latch
  assign newEvt    = intEvt & intMask;
  assign latchBase = (intLatchRd || longRise) ? '0 : intLatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intLatch <= '0;
    end else begin
      intLatch <= latchBase | newEvt;
    end
  end

  assign intOut = |intLatch;

  assign status.pcDone     = (pcCnt == PC_LAST);
  assign status.csToggle   = (chipSel != csQ);
  assign status.csLongRise = longRise;
  assign status.keepClk    = keepQ;

  assert_int_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|newEvt) |=> intOut);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (intLatchRd && !(|newEvt)) |=> !intOut);

endmodule

// File: rtl/uart_seq_ctrl.sv
module uart_seq_ctrl
  import ulpi_uart_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgUartReq,
  input  logic        stp,
  input  dpStatus_t   status,
  output ctlStrobes_t strobes,
  output logic        dir,
  output logic [7:0]  ulpiDataOut,
  output logic        ulpiDataOe,
  output logic        clkOutEn,
  output logic        pullupEn,
  output logic        uartBufEn,
  output logic        uartModeClr,
  output logic        porOut
);

  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    if (status.csLongRise) begin
      nextState = SYNC;
    end else begin
      unique case (state)
        SYNC:             if (cfgUartReq) nextState = ENTRY_TURNAROUND;
        ENTRY_TURNAROUND: nextState = PRECHARGE;
        PRECHARGE:        if (status.pcDone) nextState = UART_ACTIVE;
        UART_ACTIVE:      if (stp || status.csToggle) nextState = EXIT;
        EXIT:             nextState = SYNC;
        default:          nextState = SYNC;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= SYNC;
      porOut <= 1'b0;
    end else begin
      state  <= nextState;
      porOut <= status.csLongRise;
    end
  end

  always_comb begin
    strobes.loadKeep = (state == SYNC) && cfgUartReq;
    strobes.pcStart  = (state == ENTRY_TURNAROUND);
    strobes.pcRun    = (state == PRECHARGE);
  end

  assign dir         = (state != SYNC);
  assign ulpiDataOe  = (state == PRECHARGE);
  assign ulpiDataOut = (state == PRECHARGE) ? 8'h01 : 8'h00;
  assign pullupEn    = (state == ENTRY_TURNAROUND) || (state == PRECHARGE) ||
                       (state == UART_ACTIVE);
  assign uartBufEn   = (state == UART_ACTIVE);
  assign clkOutEn    = (state != UART_ACTIVE) || status.keepClk;
  assign uartModeClr = (state == EXIT);

  assert_turnaround_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ulpiDataOe) |-> $past(dir));

  assert_no_buf_drive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(uartBufEn && ulpiDataOe));

  assert_stp_exit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (uartBufEn && stp) |=> !uartBufEn);

  assert_por_sync_R8: assert property (@(posedge clk) disable iff (!rstN)
    porOut |-> (!dir && clkOutEn));

endmodule

// File: rtl/ulpi_uart_seq.sv
module ulpi_uart_seq
  import ulpi_uart_pkg::*;
#(
  parameter int INT_W      = 4,
  parameter int PRE_CYCLES = 5,
  parameter int PD_CYCLES  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgUartReq,
  input  logic             cfgClkKeep,
  input  logic             chipSel,
  input  logic             stp,
  input  logic [INT_W-1:0] intEvt,
  input  logic [INT_W-1:0] intMask,
  input  logic             intLatchRd,
  output logic             dir,
  output logic [7:0]       ulpiDataOut,
  output logic             ulpiDataOe,
  output logic             clkOutEn,
  output logic             pullupEn,
  output logic             uartBufEn,
  output logic             uartModeClr,
  output logic             porOut,
  output logic             intOut,
  output logic [INT_W-1:0] intLatch
);

  ctlStrobes_t strobes;
  dpStatus_t   status;

  uart_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgUartReq  (cfgUartReq),
    .stp         (stp),
    .status      (status),
    .strobes     (strobes),
    .dir         (dir),
    .ulpiDataOut (ulpiDataOut),
    .ulpiDataOe  (ulpiDataOe),
    .clkOutEn    (clkOutEn),
    .pullupEn    (pullupEn),
    .uartBufEn   (uartBufEn),
    .uartModeClr (uartModeClr),
    .porOut      (porOut)
  );

  uart_seq_datapath #(
    .INT_W      (INT_W),
    .PRE_CYCLES (PRE_CYCLES),
    .PD_CYCLES  (PD_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .cfgClkKeep (cfgClkKeep),
    .chipSel    (chipSel),
    .intEvt     (intEvt),
    .intMask    (intMask),
    .intLatchRd (intLatchRd),
    .status     (status),
    .intOut     (intOut),
    .intLatch   (intLatch)
  );

endmodule

// File: tb/tb_ulpi_uart_seq.sv
module tb_ulpi_uart_seq;

  localparam int W   = 4;
  localparam int PRE = 5;
  localparam int PD  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgUartReq = 1'b0, cfgClkKeep = 1'b0, chipSel = 1'b1, stp = 1'b0;
  logic [W-1:0] intEvt = '0, intMask = '0;
  logic intLatchRd = 1'b0;
  logic dir, ulpiDataOe, clkOutEn, pullupEn, uartBufEn, uartModeClr, porOut, intOut;
  logic [7:0] ulpiDataOut;
  logic [W-1:0] intLatch;

  always #10 clk = ~clk;

  ulpi_uart_seq #(.INT_W(W), .PRE_CYCLES(PRE), .PD_CYCLES(PD)) dut (
    .clk(clk), .rstN(rstN), .cfgUartReq(cfgUartReq), .cfgClkKeep(cfgClkKeep),
    .chipSel(chipSel), .stp(stp), .intEvt(intEvt), .intMask(intMask),
    .intLatchRd(intLatchRd), .dir(dir), .ulpiDataOut(ulpiDataOut),
    .ulpiDataOe(ulpiDataOe), .clkOutEn(clkOutEn), .pullupEn(pullupEn),
    .uartBufEn(uartBufEn), .uartModeClr(uartModeClr), .porOut(porOut),
    .intOut(intOut), .intLatch(intLatch)
  );

  // behavioural model: 0 idle, 1 turn, 2 drive, 3 uart, 4 leave
  int mSt = 0, mPc = 0, mLow = 0;
  bit mKeep = 0, mCsPrev = 1, mPor = 0;
  logic [W-1:0] mLat = '0;
  int vectors = 0, miscompares = 0;
  string scen = "R10 reset";
  bit finished = 0;

  task automatic modelStep();
    bit rise, lng, tog;
    if (!rstN) begin
      mSt = 0; mPc = 0; mLow = 0; mKeep = 0; mCsPrev = 1; mPor = 0; mLat = '0;
      return;
    end
    rise = chipSel && !mCsPrev;
    lng  = mLow > PD;
    tog  = chipSel != mCsPrev;
    mPor = rise && lng;
    mLat = ((intLatchRd || mPor) ? '0 : mLat) | (intEvt & intMask);
    if (mPor) mSt = 0;
    else begin
      case (mSt)
        0: if (cfgUartReq) begin mSt = 1; mKeep = cfgClkKeep; end
        1: begin mSt = 2; mPc = 0; end
        2: if (mPc == PRE - 1) mSt = 3; else mPc++;
        3: if (stp || tog) mSt = 4;
        default: mSt = 0;
      endcase
    end
    if (chipSel) mLow = 0; else if (mLow <= PD) mLow++;
    mCsPrev = chipSel;
  endtask

  task automatic cmp(string tag, int act, int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s [%s] at %0t: actual %0h expected %0h", tag, scen, $time, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    vectors++;
    cmp("R3 dir", dir, mSt != 0);
    cmp("R3 oe", ulpiDataOe, mSt == 2);
    cmp("R3 data", ulpiDataOut, (mSt == 2) ? 8'h01 : 8'h00);
    cmp("R1 clk", clkOutEn, !(mSt == 3 && !mKeep));
    cmp("R2 pullup", pullupEn, mSt inside {1, 2, 3});
    cmp("R4 buf", uartBufEn, mSt == 3);
    cmp("R5 clr", uartModeClr, mSt == 4);
    cmp("R8 por", porOut, mPor);
    cmp("R6 int", intOut, |mLat);
    cmp("R7 latch", intLatch, mLat);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic enterUart(bit keep);
    cfgUartReq = 1; cfgClkKeep = keep; step();
    cfgUartReq = 0; cfgClkKeep = 0;
    steps(PRE + 3);
  endtask

  initial begin
    // R10: reset state
    steps(3);
    rstN = 1; steps(2);

    scen = "R3 R1 R2 entry no keep, R5 stp exit";
    enterUart(0);
    steps(3);
    stp = 1; step(); stp = 0; steps(3);

    scen = "R1 keep clock, R5 chip-select toggle exit";
    enterUart(1);
    chipSel = 0; step(); steps(2);
    chipSel = 1; steps(3);

    scen = "R9 stp and short toggle ignored during entry";
    cfgUartReq = 1; step(); cfgUartReq = 0;
    stp = 1; step(); stp = 0;
    chipSel = 0; step(); chipSel = 1; step();
    steps(PRE);
    stp = 1; step(); stp = 0; steps(2);

    scen = "R6 masked and unmasked events";
    intMask = 4'b0101;
    intEvt = 4'b1010; step(); intEvt = 0; steps(2);
    intEvt = 4'b0100; step(); intEvt = 0; steps(2);
    intEvt = 4'b0001; step(); intEvt = 0; step();

    scen = "R7 read clear and read with new event";
    intLatchRd = 1; step(); intLatchRd = 0; steps(2);
    intEvt = 4'b0101; step(); intEvt = 0;
    intLatchRd = 1; intEvt = 4'b0001; step(); intLatchRd = 0; intEvt = 0; steps(2);

    scen = "R8 low exactly PD then rise: no reset";
    chipSel = 0; steps(PD); chipSel = 1; steps(3);

    scen = "R8 long low in UART mode then rise: reset";
    intEvt = 4'b0100; step(); intEvt = 0;
    enterUart(0);
    chipSel = 0; steps(PD + 1); chipSel = 1; steps(3);

    scen = "R8 long low during precharge aborts entry";
    chipSel = 0; steps(PD + 3);
    cfgUartReq = 1; step(); cfgUartReq = 0; step();
    intMask = 4'b1111; intEvt = 4'b0010; chipSel = 1; step(); intEvt = 0; steps(3);

    scen = "R10 reset from UART mode";
    enterUart(1);
    rstN = 0; steps(2); rstN = 1; steps(3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule